// File: doc/BRIEF.md
# Serial Register-Access Master for a Chained Memory Bus

This block is the controller end of a slow serial management bus that reaches a daisy chain of memory devices. A host hands it one register access at a time: a write or a read, a 6-bit device number, a broadcast flag, a 12-bit register number and, for writes, a 16-bit value. The block turns that request into a fixed frame of four 16-bit packets. It sends the frame on a serial data output together with a serial clock and a command line, and for reads it collects the 16-bit answer from its serial data input.

The serial clock is the system clock divided by `DIV`. Each serial period starts with a high half and ends with a low half. Outbound bits change only at the rising edge so that devices can take them on the falling edge. A frame always lasts exactly 64 serial periods. When it is over, the block raises a one-cycle completion pulse and can take the next request. Chain setup, device enumeration and pad timing are handled elsewhere.

Top module: `serial_mgmt_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sck`, `cmd`, `sdo`, `busy` and `done` are low and `rdata` is zero.
- R2: Every transaction produces exactly 64 serial clock periods of `DIV` system clocks each. Rising edges are `DIV` cycles apart, each high phase lasts `DIV/2` cycles, and `sck` stays low when idle.
- R3: `sdo` changes only together with a rising edge of `sck`. Each packet is sent most significant bit first, packets in order 0..3.
- R4: `cmd` is high for the first two serial periods of a transaction, so it reads 1 on four consecutive clock edges, and it is low for the remaining 62 periods and when idle.
- R5: Packet 0 is the request word: bits 15..12 opcode (0001 write, 0010 read), bit 11 broadcast, bits 10..5 device number, bits 4..0 zero.
- R6: Packet 1 is four zero bits followed by the 12-bit register number.
- R7: A write sends packet 2 = the 16-bit write value and packet 3 = all zeros (settling interval).
- R8: A read sends packet 2 = all zeros (access interval) and holds `sdo` at zero through packet 3. During packet 3 it samples `sdi` at each falling `sck` edge, most significant data bit first. `sdi` at any other time, including the zero marker bit ahead of the data, has no effect on `rdata`.
- R9: `rdata` takes the captured read value in the same cycle that `done` rises. A write transaction leaves `rdata` unchanged.
- R10: `busy` is high from the cycle after a request is accepted. `done` is a single-cycle pulse that comes after the 64th falling edge, and `busy` is low in that cycle.
- R11: A request presented while `busy` is high is ignored. It neither alters the frame in progress nor starts another one afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_dev | input | 6 | Target device number |
| req_bcast | input | 1 | Address all devices |
| req_addr | input | 12 | Register number |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read value |
| sck | output | 1 | Serial clock |
| cmd | output | 1 | Command framing line |
| sdo | output | 1 | Serial data toward the chain |
| sdi | input | 1 | Serial data from the chain |

## Verification
The bench builds the block with `DIV = 6`. With that value the phase counter wraps at a count that is not a power of two, and each half period is three cycles, so an off-by-one in the half-period split shows up in the measured edge spacing. The short period also lets several full 64-period frames fit in the run, among them reads with edge-case data values, a broadcast read, and a write during which a conflicting request is held on the request inputs. The device model drives ones on `sdi` outside the data slot, so any capture outside packet 3 changes the read value.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int PKT_W    = 16;
  localparam int NUM_PKT  = 4;
  localparam int TXN_BITS = PKT_W * NUM_PKT;
  localparam int BIT_W    = $clog2(TXN_BITS);
  localparam int DEV_W    = 6;
  localparam int ADDR_W   = 12;
  localparam int CMD_BITS = 2;

  localparam logic [3:0] OP_WR = 4'b0001;
  localparam logic [3:0] OP_RD = 4'b0010;

  typedef struct packed {
    logic              rd;
    logic              bcast;
    logic [DEV_W-1:0]  dev;
    logic [ADDR_W-1:0] addr;
    logic [PKT_W-1:0]  wdata;
  } smm_req_t;

  function automatic logic [PKT_W-1:0] head_word(smm_req_t r);
    return {(r.rd ? OP_RD : OP_WR), r.bcast, r.dev, 5'b0};
  endfunction
endpackage

// File: rtl/smm_phase.sv
module smm_phase #(
  parameter int DIV = 8,
  localparam int PH_W = $clog2(DIV),
  localparam int HALF = DIV / 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic wrap_o,
  output logic high_o,
  output logic mid_o
);
  logic [PH_W-1:0] ph;

  assign wrap_o = (ph == PH_W'(DIV - 1));
  assign high_o = (ph < PH_W'(HALF));
  assign mid_o  = (ph == PH_W'(HALF));

  always_ff @(posedge clk) begin
    if (rst || start_i) ph <= '0;
    else if (run_i)     ph <= wrap_o ? '0 : ph + 1'b1;
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    ph <= PH_W'(DIV - 1));
  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !start_i) |=> $stable(ph));
endmodule

// File: rtl/smm_frame.sv
module smm_frame
  import smm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             busy_i,
  input  smm_req_t         req_i,
  input  logic [BIT_W-1:0] idx_i,
  output logic             bit_o,
  output logic             is_rd_o
);
  logic [NUM_PKT-1:0][PKT_W-1:0] words;
  logic                          rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      words <= '0;
      rd_q  <= 1'b0;
    end else if (load_i) begin
      words[0] <= head_word(req_i);
      words[1] <= {{(PKT_W-ADDR_W){1'b0}}, req_i.addr};
      words[2] <= req_i.rd ? '0 : req_i.wdata;
      words[3] <= '0;
      rd_q     <= req_i.rd;
    end
  end

  assign bit_o   = words[idx_i[BIT_W-1:4]][~idx_i[3:0]];
  assign is_rd_o = rd_q;

  assert_no_load_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !load_i);
  assert_frame_hold_R11: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(words));
endmodule

// File: rtl/smm_capture.sv
module smm_capture
  import smm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             sdi_i,
  input  logic             commit_i,
  output logic [PKT_W-1:0] rdata_o
);
  logic [PKT_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      rdata_o <= '0;
    end else begin
      if (shift_i)  sh      <= {sh[PKT_W-2:0], sdi_i};
      if (commit_i) rdata_o <= sh;
    end
  end

  assert_rdata_commit_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata_o) |-> $past(commit_i));
  assert_no_shift_commit_R8: assert property (@(posedge clk) disable iff (rst)
    commit_i |-> !shift_i);
endmodule

// File: rtl/serial_mgmt_master.sv
module serial_mgmt_master
  import smm_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [5:0]  req_dev,
  input  logic        req_bcast,
  input  logic [11:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        sck,
  output logic        cmd,
  output logic        sdo,
  input  logic        sdi
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TXN_BITS - 1);

  logic             accept, run_r, fin_r, finish;
  logic [BIT_W-1:0] bitc;
  logic             wrap, high, mid;
  logic             frame_bit, is_rd, shift_en;
  smm_req_t         req;

  assign req    = '{rd: req_read, bcast: req_bcast, dev: req_dev,
                    addr: req_addr, wdata: req_wdata};
  assign accept = req_valid && !busy;
  assign finish = run_r && wrap && (bitc == LAST_BIT);

  smm_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst(rst), .start_i(accept), .run_i(run_r),
    .wrap_o(wrap), .high_o(high), .mid_o(mid)
  );

  smm_frame u_frame (
    .clk(clk), .rst(rst), .load_i(accept), .busy_i(busy), .req_i(req),
    .idx_i(bitc), .bit_o(frame_bit), .is_rd_o(is_rd)
  );

  assign shift_en = run_r && mid && is_rd && (bitc[BIT_W-1:4] == 2'd3);

  smm_capture u_cap (
    .clk(clk), .rst(rst), .shift_i(shift_en), .sdi_i(sdi),
    .commit_i(fin_r && is_rd), .rdata_o(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_r <= 1'b0;
      bitc  <= '0;
      fin_r <= 1'b0;
      done  <= 1'b0;
      busy  <= 1'b0;
      sck   <= 1'b0;
      cmd   <= 1'b0;
      sdo   <= 1'b0;
    end else begin
      if (accept) begin
        run_r <= 1'b1;
        bitc  <= '0;
      end else if (run_r && wrap) begin
        if (bitc == LAST_BIT) run_r <= 1'b0;
        else                  bitc  <= bitc + 1'b1;
      end
      fin_r <= finish;
      done  <= fin_r;
      if (accept)     busy <= 1'b1;
      else if (fin_r) busy <= 1'b0;
      sck <= run_r && high;
      cmd <= run_r && (bitc < BIT_W'(CMD_BITS));
      sdo <= run_r && frame_bit;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !sck));
  assert_sdo_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $rose(sck));
  assert_cmd_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd) |-> $rose(sck));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sck && !cmd && !sdo));
endmodule

// File: tb/serial_mgmt_master_test.sv
module serial_mgmt_master_test;
  localparam int DIV = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_read = 1'b0, req_bcast = 1'b0;
  logic [5:0] req_dev = '0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, sck, cmd, sdo;
  logic sdi = 1'b0;
  logic [15:0] rdata;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_rise = 0, rises = 0, falls = 0;
  int done_cnt = 0, done_bad = 0, width_bad = 0;
  logic sck_prev = 1'b0;
  logic [63:0] sdo_bits, cmd_r_bits, cmd_f_bits;
  logic mon_rd = 1'b0;
  logic [15:0] mon_val = '0;

  serial_mgmt_master #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
    .req_dev(req_dev), .req_bcast(req_bcast), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .sck(sck), .cmd(cmd), .sdo(sdo), .sdi(sdi)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Device model: samples on falling sck, answers on rising sck.
  always @(negedge clk) begin
    cyc++;
    if (sck && !sck_prev) begin
      if (rises > 0 && cyc - last_rise != DIV) width_bad++;
      last_rise = cyc;
      if (rises < 64) cmd_r_bits[63-rises] = cmd;
      if (mon_rd && rises >= 48 && rises < 64) sdi = mon_val[63-rises];
      else if (rises == 47) sdi = 1'b0;
      else sdi = 1'b1;
      rises++;
    end
    if (!sck && sck_prev) begin
      if (cyc - last_rise != DIV/2) width_bad++;
      if (falls < 64) begin
        sdo_bits[63-falls]   = sdo;
        cmd_f_bits[63-falls] = cmd;
      end
      falls++;
    end
    if (done) begin
      done_cnt++;
      if (falls != 64 || busy) done_bad++;
    end
    sck_prev = sck;
  end

  task automatic run_txn(input logic rd, input logic [5:0] dev, input logic bc,
                         input logic [11:0] addr, input logic [15:0] wd,
                         input logic [15:0] dev_val, input logic [15:0] exp_rdata,
                         input logic inject);
    logic [15:0] w0, w1, w2;
    int guard;
    @(negedge clk);
    rises = 0; falls = 0; done_cnt = 0; done_bad = 0; width_bad = 0;
    mon_rd = rd; mon_val = dev_val;
    req_valid = 1'b1; req_read = rd; req_dev = dev; req_bcast = bc;
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    check("R10 busy after accept", {63'b0, busy}, 64'd1);
    if (inject) begin
      req_read = ~rd; req_dev = ~dev; req_bcast = ~bc;
      req_addr = ~addr; req_wdata = ~wd;
      repeat (100) @(negedge clk);
    end
    req_valid = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check("R9 rdata at done", {48'b0, rdata}, {48'b0, exp_rdata});
    repeat (4*DIV) @(negedge clk);
    w0 = {(rd ? 4'b0010 : 4'b0001), bc, dev, 5'b0};
    w1 = {4'b0, addr};
    w2 = rd ? 16'h0 : wd;
    check("R2 rise count", 64'(rises), 64'd64);
    check("R2 fall count", 64'(falls), 64'd64);
    check("R2 edge spacing", 64'(width_bad), 64'd0);
    check("R10 single done after last fall", {32'(done_cnt), 32'(done_bad)}, {32'd1, 32'd0});
    check("R5 request packet", {48'b0, sdo_bits[63:48]}, {48'b0, w0});
    check("R6 address packet", {48'b0, sdo_bits[47:32]}, {48'b0, w1});
    check(rd ? "R8 interval packet" : "R7 data packet", {48'b0, sdo_bits[31:16]}, {48'b0, w2});
    check(rd ? "R8 sdo quiet in data slot" : "R7 interval packet", {48'b0, sdo_bits[15:0]}, 64'd0);
    check("R4 cmd at rising edges", cmd_r_bits, 64'hC000_0000_0000_0000);
    check("R4 cmd at falling edges", cmd_f_bits, 64'hC000_0000_0000_0000);
    check("R11 idle after frame", {62'b0, busy, sck}, 64'd0);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {43'b0, sck, cmd, sdo, busy, done, rdata}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {43'b0, sck, cmd, sdo, busy, done, rdata}, 64'd0);
  endtask

  initial begin
    test_reset();
    run_txn(1'b0, 6'd5, 1'b0, 12'h3A7, 16'hBEEF, 16'h0000, 16'h0000, 1'b0);
    run_txn(1'b1, 6'h2A, 1'b0, 12'h001, 16'h1234, 16'hA5C3, 16'hA5C3, 1'b0);
    run_txn(1'b1, 6'h3F, 1'b1, 12'hFFF, 16'h0000, 16'h8001, 16'h8001, 1'b0);
    // R9: a write must keep the last read value
    run_txn(1'b0, 6'h11, 1'b0, 12'h800, 16'hFFFF, 16'h0000, 16'h8001, 1'b0);
    // R11: conflicting request held during a write
    run_txn(1'b0, 6'h07, 1'b0, 12'h055, 16'h6C39, 16'h0000, 16'h8001, 1'b1);
    // R8: read of all ones with noise outside the slot
    run_txn(1'b1, 6'h00, 1'b0, 12'h0F0, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b0);
    run_txn(1'b1, 6'h15, 1'b0, 12'h0AA, 16'h0000, 16'h0000, 16'h0000, 1'b0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule